// File: doc/BRIEF.md
# Windowed Bank Mapper

This block widens a 16-bit processor address into a 21-bit physical address. The processor's 64 KiB space is cut into eight windows of 8 KiB. Each window owns an 8-bit bank register. The three top address bits pick the window. The contents of that window's register become the upper physical address lines. The 13 offset bits go straight through. Every access is translated this way, whether it fetches code or moves data.

Software remaps a window through a single write port. The write lands at the clock edge, so the access in the cycle of the write still uses the old bank, and the next access uses the new one. A separate readback port returns the bank value of any window on request. The readback has no effect on translation.

At reset every bank register clears to zero. The top window is therefore tied to bank 0, which keeps the processor's reset vector at the end of the address space reachable.

Top module: `bank_window_mapper`

## Requirements
- R1: `phys_addr[12:0]` always equals `cpu_addr[12:0]`, combinationally.
- R2: `phys_addr[20:13]` equals the bank register of window `cpu_addr[15:13]`, combinationally. Window 0 covers 0x0000 to 0x1FFF, and window 7 covers 0xE000 to 0xFFFF.
- R3: A cycle with `map_we` high loads `map_data` into the register of window `map_sel` at the rising edge. The other seven registers keep their values.
- R4: In the cycle that carries a write, translation still uses the old bank value. The new value applies from the next cycle on.
- R5: While `rst_n` is low, all eight bank registers read 0. In particular, address 0xFFFC translates to physical 0x001FFC.
- R6: `rd_data` combinationally equals the bank register of window `rd_sel`, and it changes nothing.
- R7: With `map_we` low, no bank register changes, whatever `map_sel` and `map_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| phys_addr | output | 21 | Translated physical address |
| map_we | input | 1 | Bank register write enable |
| map_sel | input | 3 | Window whose bank register is written |
| map_data | input | 8 | New bank value |
| rd_sel | input | 3 | Window whose bank value is read back |
| rd_data | output | 8 | Bank value of window `rd_sel` |

## Verification
The bench probes the edges of each window, such as 0x1FFF against 0x2000 and 0xDFFF against 0xE000. A design that decoded the wrong address bits would place those addresses in the wrong bank. It samples the physical address on both sides of the edge that carries a write. A design that bypassed the write data into translation would show the new bank one cycle early. After each write, the bench reads back every window and clocks junk data with the enable low. An address-decode slip would corrupt a neighbouring window, and a missing enable gate would change a bank, and both show on the readback. The reset vector address is translated before any programming, which exposes a top window that does not come out of reset at bank 0.

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
  parameter int CPU_AW         = 16,
  parameter int WIN_BITS       = 3,
  parameter int BANK_W         = 8,
  parameter int TOP_RESET_BANK = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CPU_AW-1:0]                 cpu_addr,
  output logic [CPU_AW-WIN_BITS+BANK_W-1:0] phys_addr,
  input  logic                              map_we,
  input  logic [WIN_BITS-1:0]               map_sel,
  input  logic [BANK_W-1:0]                 map_data,
  input  logic [WIN_BITS-1:0]               rd_sel,
  output logic [BANK_W-1:0]                 rd_data
);
  localparam int OFS_W = CPU_AW - WIN_BITS;
  localparam int NWIN  = 1 << WIN_BITS;

  logic [BANK_W-1:0]   bank_q [NWIN];
  logic [WIN_BITS-1:0] win;

  assign win       = cpu_addr[CPU_AW-1:OFS_W];
  assign phys_addr = {bank_q[win], cpu_addr[OFS_W-1:0]};
  assign rd_data   = bank_q[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++)
        bank_q[i] <= (i == NWIN-1) ? BANK_W'(TOP_RESET_BANK) : '0;
    end else if (map_we) begin
      bank_q[map_sel] <= map_data;
    end
  end

  // Translation and readback agree whenever they select the same window.
  assert_xlate_matches_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == win) |-> (phys_addr[OFS_W+BANK_W-1:OFS_W] == rd_data));

  // A written value is visible to translation on the next cycle.
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> ((win != $past(map_sel)) || (phys_addr[OFS_W+BANK_W-1:OFS_W] == $past(map_data))));

  // No early bypass: the write cycle still shows the previous mapping.
  assert_no_same_cycle_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && !$past(map_we) && $stable(cpu_addr)) |-> $stable(phys_addr));

  // Without a write enable, the readback of a held window cannot move.
  assert_idle_keeps_banks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_we && $stable(rd_sel)) |=> $stable(rd_data));

  // The offset bits reach the output whatever the bank holds.
  assert_offset_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cpu_addr[OFS_W-1:0]) |-> $stable(phys_addr[OFS_W-1:0]));
endmodule

// File: tb/sim_bank_window_mapper.sv
module sim_bank_window_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [20:0] phys_addr;
  logic        map_we = 0;
  logic [2:0]  map_sel = '0;
  logic [7:0]  map_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];

  always #10 clk = ~clk;

  bank_window_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .map_we(map_we), .map_sel(map_sel), .map_data(map_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  localparam logic [7:0] PROG [8] = '{8'h05, 8'h3C, 8'h81, 8'hFF, 8'h00, 8'h7E, 8'hC3, 8'h1A};

  // {cpu address, expected bank, expected offset}
  localparam logic [36:0] VEC [10] = '{
    {16'h0000, 8'h05, 13'h0000},
    {16'h1FFF, 8'h05, 13'h1FFF},
    {16'h2000, 8'h3C, 13'h0000},
    {16'h3ABC, 8'h3C, 13'h1ABC},
    {16'h5555, 8'h81, 13'h1555},
    {16'h6001, 8'hFF, 13'h0001},
    {16'h8000, 8'h00, 13'h0000},
    {16'hA123, 8'h7E, 13'h0123},
    {16'hDFFF, 8'hC3, 13'h1FFF},
    {16'hFFFC, 8'h1A, 13'h1FFC}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_bank(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    map_we = 1; map_sel = sel; map_data = val;
    @(negedge clk);
    map_we = 0;
    model[sel] = val;
  endtask

  task automatic readback_all(input string req);
    for (int w = 0; w < 8; w++) begin
      rd_sel = 3'(w);
      #1;
      check(req, 32'(rd_data), 32'(model[w]));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 8; w++) model[w] = 8'h00;
    repeat (3) @(negedge clk);
    // R5: state while reset is held
    cpu_addr = 16'hFFFC; #1;
    check("R5 reset vector", 32'(phys_addr), 32'h001FFC);
    readback_all("R5 reset banks");
    @(negedge clk); rst_n = 1;

    for (int w = 0; w < 8; w++) write_bank(3'(w), PROG[w]);
    readback_all("R6 readback after programming");

    // R1 R2: vector table
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cpu_addr = VEC[k][36:21]; #1;
      check("R1 offset", 32'(phys_addr[12:0]), 32'(VEC[k][12:0]));
      check("R2 bank", 32'(phys_addr[20:13]), 32'(VEC[k][20:13]));
    end

    // R4: write cycle shows old bank, next cycle shows new
    @(negedge clk);
    cpu_addr = 16'h6001;
    map_we = 1; map_sel = 3'd3; map_data = 8'h42;
    #1;
    check("R4 same cycle old bank", 32'(phys_addr), {11'd0, 8'hFF, 13'h0001});
    @(negedge clk);
    map_we = 0;
    model[3] = 8'h42;
    #1;
    check("R4 next cycle new bank", 32'(phys_addr), {11'd0, 8'h42, 13'h0001});
    // R3: only window 3 changed
    readback_all("R3 neighbours intact");

    // R7: enable low with junk on the write bus
    @(negedge clk);
    map_sel = 3'd7; map_data = 8'hEE;
    repeat (3) @(negedge clk);
    cpu_addr = 16'hE010; #1;
    check("R7 no write without enable", 32'(phys_addr), {11'd0, 8'h1A, 13'h0010});
    readback_all("R7 banks unchanged");

    // R3 again: top window, then back-to-back writes
    write_bank(3'd7, 8'hB5);
    write_bank(3'd0, 8'h99);
    cpu_addr = 16'hFFFF; #1;
    check("R3 top window write", 32'(phys_addr), {11'd0, 8'hB5, 13'h1FFF});
    cpu_addr = 16'h0004; #1;
    check("R3 window 0 write", 32'(phys_addr), {11'd0, 8'h99, 13'h0004});
    readback_all("R6 final readback");

    // R5: reset again clears everything
    @(negedge clk); rst_n = 0; #1;
    for (int w = 0; w < 8; w++) model[w] = 8'h00;
    cpu_addr = 16'hFFFC; #1;
    check("R5 reset after use", 32'(phys_addr), 32'h001FFC);
    readback_all("R5 cleared banks");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule